// File: doc/BRIEF.md
# Banked Interrupt Controller with Shortcut Status Bits

This block gathers level-sensitive interrupt sources arranged in three banks, a small basic bank of 8 lines and two wide banks of 32 lines each, and drives one IRQ line and one FIQ line toward a processor. Each bank has an enable mask. Software sets mask bits through one write-one register and clears them through another, so a single write never has to read the mask, modify it and write it back. Each wide bank reports its masked pending sources. The basic bank's status word combines its own masked sources with two summary bits and a set of shortcut bits.

A shortcut bit mirrors one frequently used source of a wide bank directly into the basic status word. A handler can then identify that source with one read. A shortcut source keeps its normal bit in its own bank's pending word. It does not raise that bank's summary bit, so the summary bit means that a non-shortcut source is waiting. A separate control register selects any single source by a flat index and routes its raw level to the FIQ output.

Top module: `irqc_banked`

## Requirements
- R1: After synchronous reset, all three enable masks and the FIQ control register are zero, and both irq and fiq are low.
- R2: A register write to offset 0x10 (bank 1), 0x14 (bank 2) or 0x18 (basic bank, bits 7:0) sets every mask bit written as 1. Mask bits written as 0 keep their value. The write takes effect at the clock edge that samples it.
- R3: A register write to offset 0x1C (bank 1), 0x20 (bank 2) or 0x24 (basic bank) clears every mask bit written as 1. Mask bits written as 0 keep their value.
- R4: Reads at 0x04 and 0x08 return the raw bank-1 and bank-2 sources ANDed with their masks, and shortcut sources are included. A read at an enable or disable offset returns that bank's current mask. The basic mask is zero-extended. Unmapped offsets read zero. Reads are combinational.
- R5: The status word at 0x00 holds the masked basic sources in bits 7:0. Bit 8 is set when an enabled pending bank-1 source outside the shortcut set is present. Bit 9 is set on the same condition for bank 2. A pending shortcut source alone sets neither bit.
- R6: Status bits 10 to 14 reflect masked bank-1 sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 reflect masked bank-2 sources 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read zero.
- R7: Writes to bits 31:8 of the basic enable and disable registers have no effect. Summary and shortcut bits are gated only by the wide bank masks.
- R8: irq is high exactly when any of status bits 20:0 is set.
- R9: The FIQ control register at 0x0C holds a source index in bits 6:0 and an enable in bit 7, and its bits 31:8 read zero. fiq equals the enable ANDed with the raw level of the indexed source. Indices 0-31 select bank 1, 32-63 select bank 2 and 64-71 select the basic bank. Indices 72 and above select no source.
- R10: FIQ routing ignores the enable masks, and the irq output ignores the FIQ control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_basic | input | 8 | Raw basic-bank source levels |
| src_b1 | input | 32 | Raw bank-1 source levels |
| src_b2 | input | 32 | Raw bank-2 source levels |
| irq | output | 1 | Interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The assertions assume that reg_wr and reg_addr are settled at each rising edge and that only one register is written per cycle. This makes concurrent set and clear of the same mask impossible. The source vectors are treated as level inputs that change only between edges. The stimulus drives every input on the falling edge, issues one write per two cycles, and compares reads half a cycle later. Random FIQ indices span the full 7-bit range, so indices that select no source are reached.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BASIC_W   = 8;
    localparam int WIDE_W    = 32;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int FIQ_IDX_W = 7;
    localparam int SC1_N     = 5;
    localparam int SC2_N     = 6;
    localparam int SUM1_BIT  = BASIC_W;
    localparam int SUM2_BIT  = BASIC_W + 1;
    localparam int SC1_LSB   = BASIC_W + 2;
    localparam int SC2_LSB   = SC1_LSB + SC1_N;
    localparam int STAT_W    = SC2_LSB + SC2_N;
    localparam int FLAT_N    = 2 * WIDE_W + BASIC_W;

    localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_PND1  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_PND2  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_FIQ   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_SET1  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_SET2  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_SET0  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_CLR1  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_CLR2  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_CLR0  = 6'h24;

    // Sources of each wide bank that own a shortcut bit
    localparam logic [WIDE_W-1:0] SC1_SEL = 32'h000C_0680;
    localparam logic [WIDE_W-1:0] SC2_SEL = 32'h43E0_0000;

    typedef struct packed {
        logic                 en;
        logic [FIQ_IDX_W-1:0] idx;
    } fiq_ctl_t;

    function automatic logic [SC1_N-1:0] pick_sc1(input logic [WIDE_W-1:0] p);
        return {p[19], p[18], p[10], p[9], p[7]};
    endfunction

    function automatic logic [SC2_N-1:0] pick_sc2(input logic [WIDE_W-1:0] p);
        return {p[30], p[25], p[24], p[23], p[22], p[21]};
    endfunction

endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wbits,
    input  logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (set_we)
            mask <= mask | wbits;
        else if (clr_we)
            mask <= mask & ~wbits;
    end

    assign pend = raw & mask;

    assert_reset_R1: assert property (@(posedge clk) rst |=> (mask == '0));

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((mask & $past(wbits)) == $past(wbits)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((mask & $past(wbits)) == '0));

    assert_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (set_we || clr_we) |=> ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

endmodule

// File: rtl/irqc_status_word.sv
module irqc_status_word
    import irqc_pkg::*;
(
    input  logic [BASIC_W-1:0] pend0,
    input  logic [WIDE_W-1:0]  pend1,
    input  logic [WIDE_W-1:0]  pend2,
    output logic [DATA_W-1:0]  stat
);

    always_comb begin
        stat                            = '0;
        stat[BASIC_W-1:0]               = pend0;
        stat[SUM1_BIT]                  = |(pend1 & ~SC1_SEL);
        stat[SUM2_BIT]                  = |(pend2 & ~SC2_SEL);
        stat[SC1_LSB +: SC1_N]          = pick_sc1(pend1);
        stat[SC2_LSB +: SC2_N]          = pick_sc2(pend2);
    end

endmodule

// File: rtl/irqc_fiq_sel.sv
module irqc_fiq_sel
    import irqc_pkg::*;
(
    input  logic [BASIC_W-1:0] raw0,
    input  logic [WIDE_W-1:0]  raw1,
    input  logic [WIDE_W-1:0]  raw2,
    input  fiq_ctl_t           ctl,
    output logic               fiq
);

    logic [FLAT_N-1:0] flat;
    logic              hit;

    // Flat order: bank 1, bank 2, then basic bank
    assign flat = {raw0, raw2, raw1};

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < FLAT_N; i++)
            if (ctl.idx == FIQ_IDX_W'(i))
                hit = flat[i];
    end

    assign fiq = ctl.en & hit;

endmodule

// File: rtl/irqc_banked.sv
module irqc_banked
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [7:0]        src_basic,
    input  logic [31:0]       src_b1,
    input  logic [31:0]       src_b2,
    output logic              irq,
    output logic              fiq
);

    logic [WIDE_W-1:0]  raw_w  [2];
    logic [WIDE_W-1:0]  mask_w [2];
    logic [WIDE_W-1:0]  pend_w [2];
    logic [BASIC_W-1:0] mask0, pend0;
    logic [DATA_W-1:0]  stat0;
    fiq_ctl_t           fiq_ctl;

    assign raw_w[0] = src_b1;
    assign raw_w[1] = src_b2;

    for (genvar b = 0; b < 2; b++) begin : g_wide
        localparam logic [ADDR_W-1:0] SET_OFF = (b == 0) ? OFF_SET1 : OFF_SET2;
        localparam logic [ADDR_W-1:0] CLR_OFF = (b == 0) ? OFF_CLR1 : OFF_CLR2;
        irqc_mask_bank #(.W(WIDE_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_we (reg_wr && reg_addr == SET_OFF),
            .clr_we (reg_wr && reg_addr == CLR_OFF),
            .wbits  (reg_wdata[WIDE_W-1:0]),
            .raw    (raw_w[b]),
            .mask   (mask_w[b]),
            .pend   (pend_w[b])
        );
    end

    irqc_mask_bank #(.W(BASIC_W)) u_basic (
        .clk    (clk),
        .rst    (rst),
        .set_we (reg_wr && reg_addr == OFF_SET0),
        .clr_we (reg_wr && reg_addr == OFF_CLR0),
        .wbits  (reg_wdata[BASIC_W-1:0]),
        .raw    (src_basic),
        .mask   (mask0),
        .pend   (pend0)
    );

    irqc_status_word u_stat (
        .pend0 (pend0),
        .pend1 (pend_w[0]),
        .pend2 (pend_w[1]),
        .stat  (stat0)
    );

    always_ff @(posedge clk) begin
        if (rst)
            fiq_ctl <= '0;
        else if (reg_wr && reg_addr == OFF_FIQ)
            fiq_ctl <= fiq_ctl_t'(reg_wdata[FIQ_IDX_W:0]);
    end

    irqc_fiq_sel u_fiq (
        .raw0 (src_basic),
        .raw1 (src_b1),
        .raw2 (src_b2),
        .ctl  (fiq_ctl),
        .fiq  (fiq)
    );

    assign irq = |stat0[STAT_W-1:0];

    always_comb begin
        case (reg_addr)
            OFF_STAT:           reg_rdata = stat0;
            OFF_PND1:           reg_rdata = pend_w[0];
            OFF_PND2:           reg_rdata = pend_w[1];
            OFF_FIQ:            reg_rdata = DATA_W'(fiq_ctl);
            OFF_SET1, OFF_CLR1: reg_rdata = mask_w[0];
            OFF_SET2, OFF_CLR2: reg_rdata = mask_w[1];
            OFF_SET0, OFF_CLR0: reg_rdata = DATA_W'(mask0);
            default:            reg_rdata = '0;
        endcase
    end

    assert_fiq_reset_R1: assert property (@(posedge clk) rst |=> (fiq_ctl == '0));

    assert_shortcut_only_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_w[0] != '0 && (pend_w[0] & ~SC1_SEL) == '0) |-> !stat0[SUM1_BIT]);

    assert_shortcut_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (src_b2[30] && mask_w[1][30]) |-> stat0[SC2_LSB + SC2_N - 1]);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (mask0 == '0 && mask_w[0] == '0 && mask_w[1] == '0) |-> !irq);

    assert_fiq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !fiq_ctl.en |-> !fiq);

endmodule

// File: tb/sim_irqc_banked.sv
`timescale 1ns/1ps
module sim_irqc_banked;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  src_basic = '0;
    logic [31:0] src_b1 = '0;
    logic [31:0] src_b2 = '0;
    logic        irq, fiq;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  m_e0 = '0;
    logic [31:0] m_e1 = '0;
    logic [31:0] m_e2 = '0;
    logic [7:0]  m_fc = '0;

    always #2 clk = ~clk;

    irqc_banked u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_basic(src_basic),
        .src_b1(src_b1), .src_b2(src_b2), .irq(irq), .fiq(fiq)
    );

    function automatic logic [31:0] exp_stat();
        logic [31:0] p1, p2, s;
        p1 = src_b1 & m_e1;
        p2 = src_b2 & m_e2;
        s = '0;
        s[7:0] = src_basic & m_e0;
        s[8]  = |(p1 & ~32'h000C_0680);
        s[9]  = |(p2 & ~32'h43E0_0000);
        s[10] = p1[7];  s[11] = p1[9];  s[12] = p1[10];
        s[13] = p1[18]; s[14] = p1[19];
        s[15] = p2[21]; s[16] = p2[22]; s[17] = p2[23];
        s[18] = p2[24]; s[19] = p2[25]; s[20] = p2[30];
        return s;
    endfunction

    function automatic logic exp_fiq();
        int idx;
        idx = int'(m_fc[6:0]);
        if (!m_fc[7]) return 1'b0;
        if (idx < 32) return src_b1[idx];
        if (idx < 64) return src_b2[idx-32];
        if (idx < 72) return src_basic[idx-64];
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            6'h10: m_e1 = m_e1 | d;
            6'h14: m_e2 = m_e2 | d;
            6'h18: m_e0 = m_e0 | d[7:0];
            6'h1C: m_e1 = m_e1 & ~d;
            6'h20: m_e2 = m_e2 & ~d;
            6'h24: m_e0 = m_e0 & ~d[7:0];
            6'h0C: m_fc = d[7:0];
            default: ;
        endcase
    endtask

    task automatic check_all();
        rd(6'h00, "R5 R6 status", exp_stat());
        rd(6'h04, "R4 pend1", src_b1 & m_e1);
        rd(6'h08, "R4 pend2", src_b2 & m_e2);
        rd(6'h0C, "R9 fiq ctl", {24'h0, m_fc});
        rd(6'h10, "R2 mask1", m_e1);
        rd(6'h20, "R3 mask2", m_e2);
        rd(6'h24, "R7 mask0", {24'h0, m_e0});
        rd(6'h2C, "R4 unmapped", 32'h0);
        check("R8 irq", {31'h0, irq}, {31'h0, |exp_stat()});
        check("R9 fiq", {31'h0, fiq}, {31'h0, exp_fiq()});
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [5:0] offs [10];
        void'($urandom(32'd4242));
        offs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24};
        src_basic = 8'hFF; src_b1 = '1; src_b2 = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 fiq", {31'h0, fiq}, 32'h0);
        rd(6'h0C, "R1 fiq ctl", 32'h0);
        rd(6'h18, "R1 mask0", 32'h0);
        rd(6'h10, "R1 mask1", 32'h0);
        rd(6'h14, "R1 mask2", 32'h0);

        // R5 R6: shortcut alone sets its bit but no summary
        src_basic = '0; src_b1 = 32'h80; src_b2 = '0;
        wr(6'h10, 32'h0000_0080);
        rd(6'h00, "R6 shortcut only", 32'h0000_0400);
        rd(6'h04, "R4 shortcut in pend1", 32'h80);
        check("R8 irq shortcut", {31'h0, irq}, 32'h1);
        src_b1 = 32'h180; wr(6'h10, 32'h100);
        rd(6'h00, "R5 summary plus shortcut", 32'h0000_0500);
        src_b2 = 32'h4000_0001; wr(6'h14, 32'h4000_0000);
        rd(6'h00, "R6 bank2 bit30", 32'h0010_0500);

        // R7 basic enable upper bits ignored
        wr(6'h18, 32'hFFFF_FF00);
        rd(6'h18, "R7 upper set ignored", 32'h0);
        wr(6'h18, 32'h0000_00A5);
        wr(6'h24, 32'hFFFF_FF01);
        rd(6'h24, "R3 basic clear", 32'h0000_00A4);
        rd(6'h00, "R7 shortcut unaffected", 32'h0010_0500);

        // R9 R10: FIQ routing independent of masks
        wr(6'h1C, 32'hFFFF_FFFF); wr(6'h20, 32'hFFFF_FFFF); wr(6'h24, 32'hFF);
        src_basic = 8'h80; src_b1 = 32'h1; src_b2 = 32'h2;
        wr(6'h0C, 32'hFFFF_FF80);
        rd(6'h0C, "R9 upper zero", 32'h80);
        check("R10 fiq unmasked", {31'h0, fiq}, 32'h1);
        check("R10 irq masked", {31'h0, irq}, 32'h0);
        wr(6'h0C, 32'h80 | 33); #0.5;
        check("R9 bank2 idx", {31'h0, fiq}, 32'h1);
        wr(6'h0C, 32'h80 | 71); #0.5;
        check("R9 basic idx 71", {31'h0, fiq}, 32'h1);
        src_basic = '1; src_b1 = '1; src_b2 = '1;
        wr(6'h0C, 32'h80 | 72); #0.5;
        check("R9 idx 72 none", {31'h0, fiq}, 32'h0);
        wr(6'h0C, 32'h05); #0.5;
        check("R9 disabled", {31'h0, fiq}, 32'h0);
        check_all();

        // Random mix
        for (int it = 0; it < 600; it++) begin
            @(negedge clk);
            src_basic = 8'($urandom); src_b1 = $urandom; src_b2 = $urandom;
            if ($urandom_range(3) == 0) src_b1 = src_b1 & 32'h000C_0680;
            wr(offs[$urandom_range(9)], $urandom);
            check_all();
        end
        finish_run();
    end

endmodule